// File: doc/BRIEF.md
# Selectable Self-Synchronizing Line Scrambler

This block whitens a serial transmit bit stream one bit per line bit clock. It uses a 23-stage self-synchronizing shift register. Each scrambled bit is the incoming bit XOR two earlier scrambled bits: the bit from 23 positions back, and the bit from either 18 or 5 positions back. A runtime select input chooses the near tap. One setting is meant for the upstream direction and the other for the downstream direction.

A per-bit qualifier marks positions that must travel uncoded, such as frame sync words and stuff bits. Those bits pass straight through and the register does not advance. A global enable input bypasses the coding completely and also freezes the register.

The same block turns into the matching descrambler when its mode input is set. In that mode it shifts the received line bit into the register instead of its own output. A descrambler with the same taps recovers the original data once 23 coded bits have passed through it, whatever state it started in.

Top module: `ssync_scrambler`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `bit_out_valid` is 0 and `bit_out` is 0. The register is cleared to all zeros.
- R2: `bit_out_valid` is `bit_valid` delayed by exactly one clock. The bit for input cycle n appears on `bit_out` in cycle n+1.
- R3: With `tap_sel`=0, every coded bit is the input bit XOR the register bit from 18 coded bits earlier XOR the register bit from 23 coded bits earlier. A coded bit is one with `bit_valid`=1, `bit_skip`=0 and `scr_on`=1.
- R4: With `tap_sel`=1, the rule of R3 uses the bit from 5 coded bits earlier in place of 18.
- R5: A bit with `bit_skip`=1 comes out equal to its input, and the register does not advance. The next coded bit therefore uses the same history as if the skipped bit had never been there.
- R6: While `scr_on`=0, every valid bit comes out equal to its input and the register holds its state.
- R7: With `descr_mode`=1, the register takes in the incoming line bit instead of the output bit. The output is the line bit XOR the two selected earlier line bits.
- R8: A second instance in descramble mode is fed the first instance's output together with the matching qualifiers, delayed by one clock. From its 24th coded bit on, it outputs exactly the original plain data, whatever its starting register contents.
- R9: A cycle with `bit_valid`=0 leaves the register and `bit_out` unchanged.
- R10: A change of `tap_sel` between two coded bits takes effect on the very next coded bit and works on the unchanged history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | A bit is presented this cycle |
| bit_in | input | 1 | Serial data bit (plain in scramble mode, line bit in descramble mode) |
| bit_skip | input | 1 | This bit is a sync or stuff position: pass uncoded, hold register |
| scr_on | input | 1 | 1 enables coding, 0 bypasses it and freezes the register |
| tap_sel | input | 1 | 0 selects near tap 18, 1 selects near tap 5 |
| descr_mode | input | 1 | 0 scrambles, 1 descrambles |
| bit_out_valid | output | 1 | Registered output qualifier |
| bit_out | output | 1 | Registered coded or passed-through bit |

## Verification
A skip position or bypass can land in the same cycle as a polynomial switch. In that cycle the bypass must win, and the switch must apply only to the following coded bit, using history the skipped bit left alone. The random phase toggles `bit_skip`, `scr_on` and `tap_sel` on independent odds so these collisions occur many times. Each output is judged against a bench model that keeps its own newest-first history and advances it only on coded bits. A chained descrambler, primed with random garbage, must then reproduce the plain stream through the same mixture.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // Register depth and the two near-tap distances.
  localparam int SCR_LEN = 23;
  localparam int TAP_UP  = 18;
  localparam int TAP_DN  = 5;

  typedef enum logic {
    TAPS_UP = 1'b0,
    TAPS_DN = 1'b1
  } tap_set_e;

  typedef enum logic {
    MODE_SCRAMBLE   = 1'b0,
    MODE_DESCRAMBLE = 1'b1
  } dir_mode_e;

  // Mod-2 sum of the data bit with both feedback bits.
  function automatic logic scr_combine(input logic d, input logic near_b, input logic far_b);
    return d ^ near_b ^ far_b;
  endfunction

  // Choose the value to feed into the register for the current mode.
  function automatic logic scr_feed(input dir_mode_e m, input logic line_b, input logic coded_b);
    return (m == MODE_DESCRAMBLE) ? line_b : coded_b;
  endfunction

endpackage

// File: rtl/scr_history.sv
module scr_history #(
  parameter int LEN = scr_pkg::SCR_LEN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           bit_new,
  output logic [LEN-1:0] hist
);

  // hist[0] is the newest entry, hist[LEN-1] the oldest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (adv) begin
      hist <= {hist[LEN-2:0], bit_new};
    end
  end

endmodule

// File: rtl/scr_tap_select.sv
module scr_tap_select #(
  parameter int LEN   = scr_pkg::SCR_LEN,
  parameter int TAP_A = scr_pkg::TAP_UP,
  parameter int TAP_B = scr_pkg::TAP_DN
) (
  input  logic           [LEN-1:0] hist,
  input  scr_pkg::tap_set_e        sel,
  output logic                     near_bit,
  output logic                     far_bit
);

  localparam int NSETS = 2;

  logic [NSETS-1:0] tap_val;

  // One pick per tap set; the distance is counted in coded bits.
  for (genvar g = 0; g < NSETS; g++) begin : g_tap
    localparam int DIST = (g == 0) ? TAP_A : TAP_B;
    assign tap_val[g] = hist[DIST-1];
  end

  assign near_bit = (sel == scr_pkg::TAPS_DN) ? tap_val[1] : tap_val[0];
  assign far_bit  = hist[LEN-1];

endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic d_next,
  output logic q_valid,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= 1'b0;
    end else begin
      q_valid <= take;
      if (take) begin
        q <= d_next;
      end
    end
  end

endmodule

// File: rtl/ssync_scrambler.sv
module ssync_scrambler #(
  parameter int LEN   = scr_pkg::SCR_LEN,
  parameter int TAP_A = scr_pkg::TAP_UP,
  parameter int TAP_B = scr_pkg::TAP_DN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic bit_skip,
  input  logic scr_on,
  input  logic tap_sel,
  input  logic descr_mode,
  output logic bit_out_valid,
  output logic bit_out
);

  import scr_pkg::*;

  // Named internal events for the checker.
  logic           active;
  logic           near_bit;
  logic           far_bit;
  logic           coded_bit;
  logic           next_out;
  logic           shift_in;
  logic [LEN-1:0] hist;

  tap_set_e  sel_e;
  dir_mode_e mode_e;

  assign sel_e  = tap_set_e'(tap_sel);
  assign mode_e = dir_mode_e'(descr_mode);

  // A bit is coded only when valid, enabled and not a reserved position.
  assign active    = bit_valid & scr_on & ~bit_skip;
  assign coded_bit = scr_combine(bit_in, near_bit, far_bit);
  assign next_out  = active ? coded_bit : bit_in;
  assign shift_in  = scr_feed(mode_e, bit_in, coded_bit);

  scr_history #(.LEN(LEN)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (active),
    .bit_new (shift_in),
    .hist    (hist)
  );

  scr_tap_select #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_taps (
    .hist     (hist),
    .sel      (sel_e),
    .near_bit (near_bit),
    .far_bit  (far_bit)
  );

  scr_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (bit_valid),
    .d_next  (next_out),
    .q_valid (bit_out_valid),
    .q       (bit_out)
  );

endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int LEN = scr_pkg::SCR_LEN
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_valid,
  input logic           bit_in,
  input logic           bit_skip,
  input logic           scr_on,
  input logic           descr_mode,
  input logic           active,
  input logic [LEN-1:0] hist,
  input logic           bit_out_valid,
  input logic           bit_out
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> bit_out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !bit_out_valid); // R2
  AST_SKIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_skip) |=> (bit_out == $past(bit_in)) && $stable(hist)); // R5
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !scr_on) |=> (bit_out == $past(bit_in)) && $stable(hist)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(hist) && $stable(bit_out)); // R9
  AST_SCR_FEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !descr_mode) |=> hist[0] == bit_out); // R3
  AST_DESCR_FEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && descr_mode) |=> hist[0] == $past(bit_in)); // R7

endmodule

bind ssync_scrambler scr_checker #(.LEN(LEN)) u_scr_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_valid     (bit_valid),
  .bit_in        (bit_in),
  .bit_skip      (bit_skip),
  .scr_on        (scr_on),
  .descr_mode    (descr_mode),
  .active        (active),
  .hist          (hist),
  .bit_out_valid (bit_out_valid),
  .bit_out       (bit_out)
);

// File: tb/test_ssync_scrambler.sv
module test_ssync_scrambler;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic v, d, sk, on, sel, md;
  logic tx_dv, tx_do;

  ssync_scrambler i_ssync_scrambler (
    .clk(clk), .rst_n(rst_n), .bit_valid(v), .bit_in(d), .bit_skip(sk),
    .scr_on(on), .tap_sel(sel), .descr_mode(md),
    .bit_out_valid(tx_dv), .bit_out(tx_do)
  );

  // Receive-side descrambler, first primed with garbage then chained.
  logic rx_src, gar;
  logic sk_d, on_d, sel_d;
  logic rx_v, rx_d, rx_sk, rx_on;
  logic rx_dv, rx_do;

  always_ff @(posedge clk) begin
    sk_d  <= sk;
    on_d  <= on;
    sel_d <= sel;
  end

  always_comb begin
    rx_v  = rx_src ? tx_dv : 1'b1;
    rx_d  = rx_src ? tx_do : gar;
    rx_sk = rx_src ? sk_d  : 1'b0;
    rx_on = rx_src ? on_d  : 1'b1;
  end

  ssync_scrambler i_rx (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_v), .bit_in(rx_d), .bit_skip(rx_sk),
    .scr_on(rx_on), .tap_sel(sel_d), .descr_mode(1'b1),
    .bit_out_valid(rx_dv), .bit_out(rx_do)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model: newest bit at index 22, bit from k coded bits ago at 23-k.
  logic [22:0] hb;
  logic exp_dv, exp_do;
  logic rx_live, rx_exp_dv, rx_exp_do, rx_exp_chk;
  int   rx_cnt;
  logic p_v, p_d, p_act;
  logic last_sel;
  string lbl;

  function automatic logic model_bit(logic [22:0] h, logic dd, logic s);
    int k;
    k = s ? 5 : 18;
    return dd ^ h[23-k] ^ h[0];
  endfunction

  function automatic logic [22:0] model_push(logic [22:0] h, logic b);
    return {b, h[22:1]};
  endfunction

  task automatic chk(string r, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s got %b want %b", r, act, expv);
    end
  endtask

  task automatic step(logic nv, logic nd, logic nsk, logic non, logic nsel, logic nmd);
    @(negedge clk);
    chk("R2 valid", tx_dv, exp_dv);
    chk(lbl, tx_do, exp_do);
    if (rx_live) begin
      chk("R2 rx valid", rx_dv, rx_exp_dv);
      if (rx_exp_chk) chk("R8 round trip", rx_do, rx_exp_do);
    end
    // receive expectation comes from the previous transmit input
    rx_live = rx_src;
    rx_exp_chk = 1'b0;
    if (rx_src) begin
      rx_exp_dv = p_v;
      if (p_v) begin
        if (!p_act) begin
          rx_exp_do = p_d; rx_exp_chk = 1'b1;
        end else begin
          if (rx_cnt >= 23) begin rx_exp_do = p_d; rx_exp_chk = 1'b1; end
          rx_cnt++;
        end
      end
    end
    v = nv; d = nd; sk = nsk; on = non; sel = nsel; md = nmd;
    gar = 1'($urandom);
    if (!nv)              lbl = "R9 idle hold";
    else if (nsk)         lbl = "R5 skip pass";
    else if (!non)        lbl = "R6 bypass";
    else if (nmd)         lbl = "R7 descramble";
    else if (nsel != last_sel) lbl = "R10 tap switch";
    else                  lbl = nsel ? "R4 tap 5" : "R3 tap 18";
    if (nv) begin
      exp_dv = 1'b1;
      if (non && !nsk) begin
        exp_do = model_bit(hb, nd, nsel);
        hb = model_push(hb, nmd ? nd : exp_do);
        last_sel = nsel;
      end else begin
        exp_do = nd;
      end
    end else begin
      exp_dv = 1'b0;
    end
    p_v = nv; p_d = nd; p_act = nv && non && !nsk;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    v = 0; d = 0; sk = 0; on = 0; sel = 0; md = 0;
    rx_src = 0; gar = 0;
    hb = '0; exp_dv = 0; exp_do = 0;
    rx_live = 0; rx_exp_dv = 0; rx_exp_do = 0; rx_exp_chk = 0; rx_cnt = 0;
    p_v = 0; p_d = 0; p_act = 0; last_sel = 0; lbl = "R1 reset";
    repeat (3) @(negedge clk);
    chk("R1 reset valid", tx_dv, 1'b0);
    chk("R1 reset data", tx_do, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release valid", tx_dv, 1'b0);
    chk("R1 after release data", tx_do, 1'b0);

    // R3 impulse through the 18-tap polynomial
    step(1, 1, 0, 1, 0, 0);
    for (int i = 0; i < 30; i++) step(1, 0, 0, 1, 0, 0);
    // R9 idle cycles in mid stream
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 0);
    // R4 impulse through the 5-tap polynomial
    step(1, 1, 0, 1, 1, 0);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 1, 1, 0);
    // R5 a sync word and four stuff bits inside live data
    for (int i = 0; i < 14; i++) step(1, 1'($urandom), 1, 1, 1, 0);
    for (int i = 0; i < 6; i++)  step(1, 1'($urandom), 0, 1, 1, 0);
    for (int i = 0; i < 4; i++)  step(1, 1, 1, 1, 0, 0);
    // R10 switch on a skipped bit, then code with new taps
    for (int i = 0; i < 25; i++) step(1, 1'($urandom), 0, 1, 0, 0);
    // R6 bypass
    for (int i = 0; i < 8; i++) step(1, 1'($urandom), 0, 0, 1, 0);
    // R7 random descramble-mode stretch with random qualifiers
    for (int i = 0; i < 300; i++)
      step(($urandom % 5) != 0, 1'($urandom), ($urandom % 7) == 0,
           ($urandom % 10) != 0, ($urandom % 20) == 0 ? ~sel : sel, ($urandom % 3) == 0);
    for (int i = 0; i < 3; i++) step(1, 1'($urandom), 0, 1, sel, 0);
    // R8 chain the descrambler onto the scrambler output
    rx_src = 1'b1;
    rx_cnt = 0;
    for (int i = 0; i < 2000; i++)
      step(($urandom % 5) != 0, 1'($urandom), ($urandom % 7) == 0,
           ($urandom % 10) != 0, ($urandom % 50) == 0 ? ~sel : sel, 1'b0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, sel, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got hang want completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule